// File: doc/BRIEF.md
# Multistandard Eight/Dual-Four Point Integer Transform

This block is a one-dimensional integer transform engine for video coding pipelines. Each accepted beat carries eight signed samples and a two-bit mode. The mode picks one of two integer coefficient sets. It also picks between one eight-point transform of all eight samples and two independent four-point transforms, one on samples 0..3 and one on samples 4..7. A single datapath serves all four modes.

The datapath has five register stages. The first is a selectable front butterfly. In eight-point mode it forms the sums and differences of mirrored sample pairs. In four-point mode it passes the samples through unchanged. The sums feed an even path and the differences feed an odd path. Each path first applies a four-input butterfly and then a mode-selected constant coefficient matrix, registered as partial products, followed by an adder tree. The odd path skips its butterfly in eight-point mode, so its adders also serve the second four-point transform. A final permutation stage orders the outputs.

The mode travels down the pipeline with its data, so every beat can use a different mode. Both edges of the block are valid/ready streams. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` is low. The sender must then hold its beat and its valid until the beat is accepted. The result must stay unchanged until it is taken.

Top module: `mst_core`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `out_ready` held high, a beat accepted at one clock edge shows up on `out_valid`/`out_data` after exactly 5 rising edges, and `out_valid` is high for exactly one cycle per accepted beat.
- R3: Mode 0 (bit1=0 eight-point, bit0=0 set A) outputs T(k) = sum over n of M(k,n)·x(n), using DCT-structured rows. The constants are c0=8, c2=8, c6=4, c1=12, c3=10, c5=6, c7=3. Row 0 is all c0. Row 4 is c0·[1 -1 -1 1 1 -1 -1 1]. Row 2 is [c2 c6 -c6 -c2 -c2 -c6 c6 c2]. Row 6 is [c6 -c2 c2 -c6 -c6 c2 -c2 c6]. The first halves of the odd rows are row 1 [c1 c3 c5 c7], row 3 [c3 -c7 -c1 -c5], row 5 [c5 -c1 c7 c3] and row 7 [c7 -c5 c3 -c1]; each odd row's second half is its first half mirrored and negated. Outputs come in natural order T0..T7.
- R4: Mode 1 (eight-point, set B) uses the same structure with c0=12, c2=16, c6=6, c1=16, c3=15, c5=9, c7=4.
- R5: Mode 2 (bit1=1 dual four-point, set A) puts the four-point transform of x0..x3 on T0..T3 and that of x4..x7 on T4..T7. The rows are [c0 c0 c0 c0], [c2 c6 -c6 -c2], [c0 -c0 -c0 c0] and [c6 -c2 c2 -c6], with c0=1, c2=2, c6=1.
- R6: Mode 3 (dual four-point, set B) is the same as R5 with c0=17, c2=22, c6=10.
- R7: The mode is captured with each beat. Back-to-back beats with a different mode on every cycle each produce the result of their own mode, in order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. During that time `in_ready` is low and an offered beat is not taken; it is taken once the stall ends, and its result appears exactly once.
- R9: Results are exact with no overflow for every input in the signed `IN_W`-bit range in every mode. This includes all-maximum, all-minimum and alternating-sign inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_mode | input | 2 | bit1: 1 = dual four-point, 0 = eight-point; bit0: coefficient set B |
| in_data | input | 8*IN_W | Eight signed samples, sample n at bits [n*IN_W +: IN_W] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8*(IN_W+11) | Eight signed results, T(k) at bits [k*(IN_W+11) +: IN_W+11] |

## Verification
Several properties are checked on every clock by the assertions. The output is quiet during reset. A result held under back-pressure keeps its valid and its data. The front stage does not move while the pipeline is frozen. `in_ready` is low only while a result is waiting. A new result is only raised from a beat that was present one stage earlier. The arithmetic itself, the coefficient sets, the two output orderings, the five-cycle latency and the per-beat mode switching can only be shown by the bench's scenarios. These compare every output word against a matrix-product reference across all four modes, with extreme and alternating-sign samples.

// File: rtl/mst_pkg.sv
package mst_pkg;

  // mode[1]: dual four-point, mode[0]: coefficient set B
  localparam int COEF_W = 6;

  // Coefficient of output row j (0..3) applied to path operand i (0..3).
  // Even path operands: {A0+A1, A0-A1, B0, B1}; rows -> Z0, Z2, Z4, Z6.
  // Odd path, eight-point: operands are the raw differences; rows -> Z1, Z3, Z5, Z7.
  // Odd path, four-point: same sparse matrix as the even path.
  function automatic int coef(input logic [1:0] mode, input bit odd, input int j, input int i);
    int c0, c2, c6, c1, c3, c5, c7, r;
    if (mode[1]) begin
      c0 = mode[0] ? 17 : 1;
      c2 = mode[0] ? 22 : 2;
      c6 = mode[0] ? 10 : 1;
    end else begin
      c0 = mode[0] ? 12 : 8;
      c2 = mode[0] ? 16 : 8;
      c6 = mode[0] ? 6  : 4;
    end
    c1 = mode[0] ? 16 : 12;
    c3 = mode[0] ? 15 : 10;
    c5 = mode[0] ? 9  : 6;
    c7 = mode[0] ? 4  : 3;
    r = 0;
    if (odd && !mode[1]) begin
      case (j * 4 + i)
        0:  r = c1;  1:  r = c3;  2:  r = c5;  3:  r = c7;
        4:  r = c3;  5:  r = -c7; 6:  r = -c1; 7:  r = -c5;
        8:  r = c5;  9:  r = -c1; 10: r = c7;  11: r = c3;
        12: r = c7;  13: r = -c5; 14: r = c3;  15: r = -c1;
        default: r = 0;
      endcase
    end else begin
      case (j * 4 + i)
        0:  r = c0;
        6:  r = c2;
        7:  r = c6;
        9:  r = c0;
        14: r = c6;
        15: r = -c2;
        default: r = 0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/mst_butterfly.sv
module mst_butterfly #(
  parameter int IN_W = 12,
  localparam int B_W = IN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   four,
  input  logic signed [IN_W-1:0] x [8],
  output logic signed [B_W-1:0]  q [8]
);

  logic signed [B_W-1:0] nxt [8];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      if (four) begin
        nxt[i]     = B_W'(x[i]);
        nxt[4 + i] = B_W'(x[4 + i]);
      end else begin
        nxt[i]     = B_W'(x[i]) + B_W'(x[7 - i]);
        nxt[4 + i] = B_W'(x[i]) - B_W'(x[7 - i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!rst_n)  q[i] <= '0;
      else if (en) q[i] <= nxt[i];
    end
  end

  p_bfly_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q[0]) && $stable(q[7]))
    else $error("front stage moved while frozen");

endmodule

// File: rtl/mst_path.sv
module mst_path
  import mst_pkg::*;
#(
  parameter int W   = 13,
  parameter bit ODD = 1'b0,
  localparam int U_W = W + 2,
  localparam int P_W = U_W + COEF_W,
  localparam int Z_W = P_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 four_s1,
  input  logic [1:0]           mode_s2,
  input  logic signed [W-1:0]  d [4],
  output logic signed [Z_W-1:0] z [4]
);

  logic signed [U_W-1:0] u_n [4];
  logic signed [U_W-1:0] u   [4];
  logic signed [P_W-1:0] p_n [4][4];
  logic signed [P_W-1:0] p   [4][4];
  logic signed [Z_W-1:0] z_n [4];

  // stage A: four-input butterfly (bypassed on the odd side for eight-point)
  always_comb begin
    logic signed [U_W-1:0] s0, s1, t0, t1;
    s0 = U_W'(d[0]) + U_W'(d[3]);
    s1 = U_W'(d[1]) + U_W'(d[2]);
    t0 = U_W'(d[0]) - U_W'(d[3]);
    t1 = U_W'(d[1]) - U_W'(d[2]);
    if (ODD && !four_s1) begin
      for (int i = 0; i < 4; i++) u_n[i] = U_W'(d[i]);
    end else begin
      u_n[0] = s0 + s1;
      u_n[1] = s0 - s1;
      u_n[2] = t0;
      u_n[3] = t1;
    end
  end

  // stage B: mode-selected constant products
  always_comb begin
    logic signed [COEF_W-1:0] k;
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 4; i++) begin
        k = COEF_W'(coef(mode_s2, ODD, j, i));
        p_n[j][i] = u[i] * k;
      end
    end
  end

  // stage C: adder tree per output
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      z_n[j] = (Z_W'(p[j][0]) + Z_W'(p[j][1])) + (Z_W'(p[j][2]) + Z_W'(p[j][3]));
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < 4; j++) begin
      if (!rst_n) begin
        u[j] <= '0;
        z[j] <= '0;
        for (int i = 0; i < 4; i++) p[j][i] <= '0;
      end else if (en) begin
        u[j] <= u_n[j];
        z[j] <= z_n[j];
        for (int i = 0; i < 4; i++) p[j][i] <= p_n[j][i];
      end
    end
  end

endmodule

// File: rtl/mst_permute.sv
module mst_permute #(
  parameter int Z_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  four,
  input  logic signed [Z_W-1:0] ze [4],
  input  logic signed [Z_W-1:0] zo [4],
  output logic signed [Z_W-1:0] t  [8]
);

  logic signed [Z_W-1:0] t_n [8];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (four) begin
        t_n[k]     = ze[k];
        t_n[4 + k] = zo[k];
      end else begin
        t_n[2 * k]     = ze[k];
        t_n[2 * k + 1] = zo[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 8; k++) begin
      if (!rst_n)  t[k] <= '0;
      else if (en) t[k] <= t_n[k];
    end
  end

endmodule

// File: rtl/mst_core.sv
module mst_core
  import mst_pkg::*;
#(
  parameter int IN_W = 12,
  localparam int B_W   = IN_W + 1,
  localparam int OUT_W = IN_W + 3 + COEF_W + 2,
  localparam int DEPTH = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_mode,
  input  logic [8*IN_W-1:0]    in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [8*OUT_W-1:0]   out_data
);

  logic                   en;
  logic [DEPTH-1:0]       vld;
  logic [1:0]             mode_q [DEPTH-1];
  logic signed [IN_W-1:0] xin [8];
  logic signed [B_W-1:0]  bq  [8];
  logic signed [B_W-1:0]  ev_d [4];
  logic signed [B_W-1:0]  od_d [4];
  logic signed [OUT_W-1:0] ze [4];
  logic signed [OUT_W-1:0] zo [4];
  logic signed [OUT_W-1:0] tq [8];

  assign out_valid = vld[DEPTH-1];
  assign en        = !out_valid || out_ready;
  assign in_ready  = en;

  always_comb begin
    for (int n = 0; n < 8; n++) xin[n] = in_data[n*IN_W +: IN_W];
    for (int i = 0; i < 4; i++) begin
      ev_d[i] = bq[i];
      od_d[i] = bq[4 + i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < DEPTH-1; s++) mode_q[s] <= '0;
    end else if (en) begin
      vld <= {vld[DEPTH-2:0], in_valid};
      mode_q[0] <= in_mode;
      for (int s = 1; s < DEPTH-1; s++) mode_q[s] <= mode_q[s-1];
    end
  end

  mst_butterfly #(.IN_W(IN_W)) u_bfly (
    .clk(clk), .rst_n(rst_n), .en(en), .four(in_mode[1]), .x(xin), .q(bq)
  );

  mst_path #(.W(B_W), .ODD(1'b0)) u_even (
    .clk(clk), .rst_n(rst_n), .en(en), .four_s1(mode_q[0][1]),
    .mode_s2(mode_q[1]), .d(ev_d), .z(ze)
  );

  mst_path #(.W(B_W), .ODD(1'b1)) u_odd (
    .clk(clk), .rst_n(rst_n), .en(en), .four_s1(mode_q[0][1]),
    .mode_s2(mode_q[1]), .d(od_d), .z(zo)
  );

  mst_permute #(.Z_W(OUT_W)) u_perm (
    .clk(clk), .rst_n(rst_n), .en(en), .four(mode_q[3][1]),
    .ze(ze), .zo(zo), .t(tq)
  );

  for (genvar k = 0; k < 8; k++) begin : g_pack
    assign out_data[k*OUT_W +: OUT_W] = tq[k];
  end

  p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid)
    else $error("result raised during reset");

  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("waiting result changed");

  p_ready_only_blocked_by_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready)
    else $error("input blocked without a waiting result");

  p_result_from_prior_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(vld[DEPTH-2]))
    else $error("result raised without a beat behind it");

endmodule

// File: tb/sim_mst_core.sv
module sim_mst_core;

  localparam int IN_W  = 12;
  localparam int OUT_W = IN_W + 11;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_mode = 2'd0;
  logic [8*IN_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [8*OUT_W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mst_core #(.IN_W(IN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  function automatic void ref_calc(input logic [1:0] md, input int v[8], output longint e[8]);
    int c0, c2, c6, c1, c3, c5, c7;
    int m8 [8][8];
    int m4 [4][4];
    c1 = md[0] ? 16 : 12; c3 = md[0] ? 15 : 10; c5 = md[0] ? 9 : 6; c7 = md[0] ? 4 : 3;
    if (md[1]) begin
      c0 = md[0] ? 17 : 1; c2 = md[0] ? 22 : 2; c6 = md[0] ? 10 : 1;
      m4[0] = '{c0, c0, c0, c0};
      m4[1] = '{c2, c6, -c6, -c2};
      m4[2] = '{c0, -c0, -c0, c0};
      m4[3] = '{c6, -c2, c2, -c6};
      for (int k = 0; k < 4; k++) begin
        e[k] = 0; e[4+k] = 0;
        for (int n = 0; n < 4; n++) begin
          e[k]   += longint'(m4[k][n]) * v[n];
          e[4+k] += longint'(m4[k][n]) * v[4+n];
        end
      end
    end else begin
      c0 = md[0] ? 12 : 8; c2 = md[0] ? 16 : 8; c6 = md[0] ? 6 : 4;
      m8[0] = '{c0, c0, c0, c0, c0, c0, c0, c0};
      m8[1] = '{c1, c3, c5, c7, -c7, -c5, -c3, -c1};
      m8[2] = '{c2, c6, -c6, -c2, -c2, -c6, c6, c2};
      m8[3] = '{c3, -c7, -c1, -c5, c5, c1, c7, -c3};
      m8[4] = '{c0, -c0, -c0, c0, c0, -c0, -c0, c0};
      m8[5] = '{c5, -c1, c7, c3, -c3, -c7, c1, -c5};
      m8[6] = '{c6, -c2, c2, -c6, -c6, c2, -c2, c6};
      m8[7] = '{c7, -c5, c3, -c1, c1, -c3, c5, -c7};
      for (int k = 0; k < 8; k++) begin
        e[k] = 0;
        for (int n = 0; n < 8; n++) e[k] += longint'(m8[k][n]) * v[n];
      end
    end
  endfunction

  function automatic longint got(input int k);
    logic signed [OUT_W-1:0] w;
    w = out_data[k*OUT_W +: OUT_W];
    return longint'(w);
  endfunction

  task automatic drive(input logic [1:0] md, input int v[8]);
    in_mode = md;
    for (int n = 0; n < 8; n++) in_data[n*IN_W +: IN_W] = IN_W'(v[n]);
    in_valid = 1'b1;
  endtask

  task automatic cmp_out(input longint e[8], input string req, input string what);
    bit bad = 0;
    checks++;
    for (int k = 0; k < 8; k++) begin
      if (!bad && got(k) != e[k]) begin
        bad = 1;
        errors++;
        $display("FAIL %s %s: T%0d actual %0d expected %0d", req, what, k, got(k), e[k]);
      end
    end
  endtask

  // send one beat with out_ready high; return latency in edges, then compare
  task automatic one_beat(input logic [1:0] md, input int v[8], input string req,
                          input string what, output int lat);
    longint e[8];
    ref_calc(md, v, e);
    @(negedge clk);
    drive(md, v);
    lat = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
      if (out_valid) break;
    end
    cmp_out(e, req, what);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset: out_valid=%0b in_ready=%0b expected 0/1", out_valid, in_ready);
    end
  endtask

  task automatic t_latency();
    int v[8] = '{1, 0, 0, 0, 0, 0, 0, 0};
    int lat;
    one_beat(2'd0, v, "R2", "impulse", lat);
    checks++;
    if (lat != 5) begin
      errors++;
      $display("FAIL R2 latency actual %0d expected 5", lat);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 out_valid width actual %0b expected 0", out_valid);
    end
  endtask

  task automatic t_mode(input logic [1:0] md, input string req);
    int ramp[8] = '{0, 1, 2, 3, 4, 5, 6, 7};
    int mix[8]  = '{100, -37, 512, -900, 13, 777, -2048, 2047};
    int imp[8]  = '{0, 0, 0, 0, 0, 9, 0, 0};
    int lat;
    one_beat(md, ramp, req, "ramp", lat);
    one_beat(md, mix, req, "mixed", lat);
    one_beat(md, imp, req, "impulse", lat);
  endtask

  task automatic t_extremes();
    int vmax[8] = '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047};
    int vmin[8] = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
    int alt[8]  = '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048};
    int half[8] = '{-2048, -2048, -2048, -2048, 2047, 2047, 2047, 2047};
    int lat;
    for (int md = 0; md < 4; md++) begin
      one_beat(2'(md), vmax, "R9", "all-max", lat);
      one_beat(2'(md), vmin, "R9", "all-min", lat);
      one_beat(2'(md), alt,  "R9", "alternating", lat);
      one_beat(2'(md), half, "R9", "split-sign", lat);
    end
  endtask

  task automatic t_stream();
    longint e[8][8];
    int v[8];
    int idx = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (out_valid) begin
        if (idx < 8) cmp_out(e[idx], "R7", "stream beat");
        idx++;
      end
      if (c < 8) begin
        for (int n = 0; n < 8; n++) v[n] = ((c + 3) * (n * 331 - 1111)) % 2048;
        ref_calc(2'(c % 4), v, e[c]);
        drive(2'(c % 4), v);
      end else begin
        in_valid = 1'b0;
      end
    end
    checks++;
    if (idx != 8) begin
      errors++;
      $display("FAIL R7 stream result count actual %0d expected 8", idx);
    end
  endtask

  task automatic t_stall();
    int vx[8] = '{300, -200, 100, 0, -50, 60, -700, 800};
    int vy[8] = '{5, 6, -7, 8, -9, 10, 11, -12};
    longint ex[8];
    longint ey[8];
    logic [8*OUT_W-1:0] snap;
    int cnt;
    int seen;
    ref_calc(2'd1, vx, ex);
    ref_calc(2'd2, vy, ey);
    @(negedge clk);
    drive(2'd1, vx);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid) break;
    end
    cmp_out(ex, "R8", "before stall");
    snap = out_data;
    out_ready = 1'b0;
    drive(2'd2, vy);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b1 || out_data !== snap || in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R8 stall cycle %0d: valid=%0b ready=%0b data_same=%0b expected 1/0/1",
                 c, out_valid, in_ready, out_data === snap);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8 held result repeated: out_valid actual %0b expected 0", out_valid);
    end
    cnt = 1;
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      cnt++;
      if (out_valid) begin
        seen++;
        if (seen == 1) begin
          cmp_out(ey, "R8", "beat offered during stall");
          checks++;
          if (cnt != 5) begin
            errors++;
            $display("FAIL R8 offered beat latency actual %0d expected 5", cnt);
          end
        end
      end
    end
    checks++;
    if (seen != 1) begin
      errors++;
      $display("FAIL R8 offered beat results actual %0d expected 1", seen);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_mode(2'd0, "R3");
    t_mode(2'd1, "R4");
    t_mode(2'd2, "R5");
    t_mode(2'd3, "R6");
    t_extremes();
    t_stream();
    t_stall();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule